// File: doc/BRIEF.md
# Big-Endian Word Load/Store Unit

This block holds a small byte-addressed data memory and serves one word access per clock. Each request carries a 32-bit base value, a signed 16-bit displacement, a direction flag and 32-bit write data. The block adds the sign-extended displacement to the base to form the effective address. It then checks that the address falls on a word boundary. Finally it either splits the write data into four bytes or gathers four bytes into a word. The most significant byte always sits at the lowest address.

Loads can also ask for a single byte at any address. That byte comes back zero-extended. Every request gets a one-cycle response slot, whether it is a read or a write. A word access that is not on a word boundary is flagged in its response, and a flagged write leaves memory untouched. Only the low address bits index the memory, so an address past the end wraps around to the start.

Top module: `be_word_lsu`

## Requirements
- R1: The effective address is `req_base` plus `req_ofs` sign-extended from bit 15. Only its low log2(MEM_BYTES) bits (8 by default) select a byte, so addresses wrap modulo MEM_BYTES. A negative displacement reaches below the base.
- R2: An aligned word store writes `req_wdata[31:24]` to the byte at the effective address EA, `[23:16]` to EA+1, `[15:8]` to EA+2 and `[7:0]` to EA+3.
- R3: An aligned word load returns `{byte[EA], byte[EA+1], byte[EA+2], byte[EA+3]}` on `rsp_data`, with `rsp_err` low.
- R4: `rsp_vld` is high in the cycle right after each accepted request (`req_vld` high), whether load or store. It is low in every other cycle, and `rsp_data` reads zero whenever `rsp_vld` is low.
- R5: A word access whose effective address has bits [1:0] not equal to 00 gives `rsp_err` high with `rsp_data` zero. If it is a store, no memory byte changes.
- R6: A load with `req_byte` high returns `{24'b0, byte[EA]}` for any EA, aligned or not, with `rsp_err` low.
- R7: An accepted store responds with `rsp_data` zero. The `req_byte` flag has no effect on stores: a store always writes a full word, under the alignment rule of R5.
- R8: A load issued in the cycle right after a store to the same word returns the newly stored word.
- R9: During reset, `rsp_vld`, `rsp_err` and `rsp_data` are held at zero and every memory byte is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_vld | input | 1 | A request is presented this cycle |
| req_store | input | 1 | 1 = word store, 0 = load |
| req_byte | input | 1 | On loads, return a single zero-extended byte |
| req_base | input | 32 | Base register value |
| req_ofs | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data |
| rsp_vld | output | 1 | Response slot, one cycle after the request |
| rsp_err | output | 1 | Word access was not word aligned |
| rsp_data | output | 32 | Load result, zero otherwise |

## Verification
The bench builds the block with the default `MEM_BYTES` of 256, so the index is 8 bits wide. At that size a 32-bit base near the top of the window actually wraps, and the test uses such bases with both positive and negative displacements. The memory is small enough that a long pseudo-random run of mixed stores, word loads and byte loads revisits the same words often. That exercises store-then-load ordering and lets the bench confirm that rejected stores leave memory untouched.

// File: rtl/be_lsu_pkg.sv
// Shared widths for the big-endian load/store unit.
// Assumes a 32-bit word of four 8-bit lanes; lane 0 is the most significant.
package be_lsu_pkg;
    localparam int WORD_W = 32;
    localparam int OFS_W  = 16;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);
endpackage

// File: rtl/lsu_ea_calc.sv
// Effective address former: base plus sign-extended displacement.
// Also reports whether the result is off a word boundary.
// Purely combinational; assumes OFS_W < WORD_W.
module lsu_ea_calc
    import be_lsu_pkg::*;
(
    input  logic [WORD_W-1:0] base,
    input  logic [OFS_W-1:0]  ofs,
    output logic [WORD_W-1:0] ea,
    output logic              misalign
);
    logic [WORD_W-1:0] ofs_ext;

    // Widen the displacement by copying its top bit.
    always_comb ofs_ext = {{(WORD_W-OFS_W){ofs[OFS_W-1]}}, ofs};

    // Sum and boundary test.
    always_comb begin
        ea       = base + ofs_ext;
        misalign = |ea[LANE_W-1:0];
    end
endmodule

// File: rtl/lsu_byte_bank.sv
// One byte lane of the data memory: ROWS entries of BYTE_W bits.
// Synchronous write and reset-to-zero, asynchronous read of the same row.
// Assumes the caller gates 'we' for alignment and direction.
module lsu_byte_bank
    import be_lsu_pkg::*;
#(
    parameter int ROWS  = 64,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] rbyte
);
    logic [BYTE_W-1:0] cells [ROWS];

    // Clear on reset, otherwise write the addressed row when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) cells[i] <= '0;
        end else if (we) begin
            cells[row] <= wbyte;
        end
    end

    // Read port follows the addressed row.
    always_comb rbyte = cells[row];
endmodule

// File: rtl/be_word_lsu.sv
// Big-endian word load/store unit with an internal byte-addressed memory.
// One request per cycle; the response register drives a one-cycle slot
// carrying load data, the alignment flag and a valid pulse.
// Assumes MEM_BYTES is a power of two and a multiple of the lane count.
module be_word_lsu
    import be_lsu_pkg::*;
#(
    parameter int MEM_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic              req_store,
    input  logic              req_byte,
    input  logic [WORD_W-1:0] req_base,
    input  logic [OFS_W-1:0]  req_ofs,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_vld,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_data
);
    localparam int IDX_W = $clog2(MEM_BYTES);
    localparam int ROWS  = MEM_BYTES / LANES;
    localparam int ROW_W = $clog2(ROWS);

    logic [WORD_W-1:0] ea;
    logic              misalign;
    logic [ROW_W-1:0]  row;
    logic [LANE_W-1:0] lane_sel;
    logic              byte_load;
    logic              bad_word;
    logic              wr_ok;
    logic [BYTE_W-1:0] lane_rd [LANES];
    logic [WORD_W-1:0] ld_word;
    logic [WORD_W-1:0] nxt_data;
    logic              nxt_err;

    lsu_ea_calc u_ea (
        .base     (req_base),
        .ofs      (req_ofs),
        .ea       (ea),
        .misalign (misalign)
    );

    // Split the address into row and lane, classify the request.
    always_comb begin
        row       = ea[IDX_W-1:LANE_W];
        lane_sel  = ea[LANE_W-1:0];
        byte_load = ~req_store & req_byte;
        bad_word  = misalign & ~byte_load;
        wr_ok     = req_vld & req_store & ~misalign;
    end

    // One bank per lane; lane g carries byte g of the word counting from the MSB.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lsu_byte_bank #(.ROWS(ROWS)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_ok),
            .row   (row),
            .wbyte (req_wdata[WORD_W-1-BYTE_W*g -: BYTE_W]),
            .rbyte (lane_rd[g])
        );
    end

    // Gather the four lanes into a word, lowest address in the top byte.
    always_comb begin
        ld_word = '0;
        for (int i = 0; i < LANES; i++)
            ld_word[WORD_W-1-BYTE_W*i -: BYTE_W] = lane_rd[i];
    end

    // Choose what the response slot will carry.
    always_comb begin
        nxt_err  = req_vld & bad_word;
        nxt_data = '0;
        if (req_vld && !req_store && !bad_word)
            nxt_data = byte_load ? {{(WORD_W-BYTE_W){1'b0}}, lane_rd[lane_sel]}
                                 : ld_word;
    end

    // Response register: one-cycle slot after every request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld  <= 1'b0;
            rsp_err  <= 1'b0;
            rsp_data <= '0;
        end else begin
            rsp_vld  <= req_vld;
            rsp_err  <= nxt_err;
            rsp_data <= nxt_data;
        end
    end
endmodule

// File: rtl/be_word_lsu_chk.sv
// Protocol checker for be_word_lsu, attached by bind. Observes ports only.
module be_word_lsu_chk
    import be_lsu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_vld,
    input logic              req_store,
    input logic              req_byte,
    input logic [WORD_W-1:0] req_base,
    input logic [OFS_W-1:0]  req_ofs,
    input logic              rsp_vld,
    input logic              rsp_err,
    input logic [WORD_W-1:0] rsp_data
);
    logic [1:0] low_sum;

    // Low two bits of the effective address, from the request ports.
    always_comb low_sum = req_base[1:0] + req_ofs[1:0];

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld); // R4
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!rsp_vld && rsp_data == '0 && !rsp_err)); // R4
    AST_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !(req_byte && !req_store) && low_sum != 2'b00)
        |=> (rsp_err && rsp_data == '0)); // R5
    AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_byte && !req_store)
        |=> (rsp_data[WORD_W-1:BYTE_W] == '0 && !rsp_err)); // R6
    AST_STORE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_store) |=> (rsp_data == '0)); // R7
endmodule

bind be_word_lsu be_word_lsu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (req_vld),
    .req_store (req_store),
    .req_byte  (req_byte),
    .req_base  (req_base),
    .req_ofs   (req_ofs),
    .rsp_vld   (rsp_vld),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data)
);

// File: tb/be_word_lsu_bench.sv
// Bench: behavioural byte-array model, compared against the outputs every cycle.
module be_word_lsu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic        req_store = 1'b0;
    logic        req_byte = 1'b0;
    logic [31:0] req_base = '0;
    logic [15:0] req_ofs = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_vld;
    logic        rsp_err;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    byte unsigned model [256];
    bit          exp_vld = 1'b0;
    bit          exp_err = 1'b0;
    logic [31:0] exp_data = '0;
    string       exp_tag = "R9";
    logic [31:0] lfsr = 32'h1ACE_B00C;

    be_word_lsu u_be_word_lsu (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_store(req_store),
        .req_byte(req_byte), .req_base(req_base), .req_ofs(req_ofs),
        .req_wdata(req_wdata), .rsp_vld(rsp_vld), .rsp_err(rsp_err),
        .rsp_data(rsp_data)
    );

    always #10 clk = ~clk;

    task automatic compare();
        checks++;
        if (rsp_vld !== exp_vld || rsp_err !== exp_err || rsp_data !== exp_data) begin
            errors++;
            $display("FAIL %s: vld/err/data actual %0b/%0b/%08h expected %0b/%0b/%08h",
                     exp_tag, rsp_vld, rsp_err, rsp_data, exp_vld, exp_err, exp_data);
        end
    endtask

    // One cycle: check last response, then present the next request and predict.
    task automatic apply(input bit v, input bit st, input bit by, input logic [31:0] b,
                         input logic [15:0] o, input logic [31:0] wd, input string tag);
        logic [31:0] ea;
        int idx;
        @(negedge clk);
        compare();
        req_vld = v; req_store = st; req_byte = by;
        req_base = b; req_ofs = o; req_wdata = wd;
        ea  = b + {{16{o[15]}}, o};
        idx = int'(ea[7:0]);
        exp_vld = v; exp_err = 1'b0; exp_data = '0;
        if (!v) exp_tag = (tag == "") ? "R4" : tag;
        else if (st) begin
            if (ea[1:0] != 2'b00) begin
                exp_err = 1'b1; exp_tag = (tag == "") ? "R5" : tag;
            end else begin
                for (int k = 0; k < 4; k++) model[idx+k] = wd[31-8*k -: 8];
                exp_tag = (tag == "") ? "R7" : tag;
            end
        end else if (by) begin
            exp_data = {24'b0, model[idx]};
            exp_tag = (tag == "") ? "R6" : tag;
        end else if (ea[1:0] != 2'b00) begin
            exp_err = 1'b1; exp_tag = (tag == "") ? "R5" : tag;
        end else begin
            exp_data = {model[idx], model[idx+1], model[idx+2], model[idx+3]};
            exp_tag = (tag == "") ? "R3" : tag;
        end
    endtask

    task automatic idle(); apply(1'b0, 1'b0, 1'b0, '0, '0, '0, "R4"); endtask

    function automatic logic [31:0] step_lfsr(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare();                 // R9 outputs held at zero in reset
        rst_n = 1'b1;
        // R9: memory cleared after reset
        apply(1, 0, 0, 32'h0, 16'h0040, '0, "R9");
        apply(1, 0, 1, 32'h0, 16'h00F3, '0, "R9");
        // R2 / R3: big-endian split and gather
        apply(1, 1, 0, 32'h0, 16'h0010, 32'hA1B2_C3D4, "R2");
        apply(1, 0, 0, 32'h0, 16'h0010, '0, "R8");
        apply(1, 0, 1, 32'h0, 16'h0010, '0, "R2");
        apply(1, 0, 1, 32'h0, 16'h0011, '0, "R2");
        apply(1, 0, 1, 32'h0, 16'h0012, '0, "R6");
        apply(1, 0, 1, 32'h0, 16'h0013, '0, "R6");
        idle();
        // R1: array index 4 from base 8 lands at 24
        apply(1, 1, 0, 32'd8, 16'd16, 32'h1122_3344, "R1");
        apply(1, 0, 0, 32'd24, 16'd0, '0, "R1");
        // R1: negative displacement and wrap-around
        apply(1, 1, 0, 32'h1000_0100, 16'hFFF8, 32'hDEAD_BEEF, "R1");
        apply(1, 0, 0, 32'h0000_00F0, 16'h0008, '0, "R1");
        apply(1, 1, 0, 32'h7FFF_FFFC, 16'h0008, 32'h0BAD_F00D, "R1");
        apply(1, 0, 0, 32'h0, 16'h0004, '0, "R1");
        // R5: misaligned store leaves memory alone; misaligned load flagged
        apply(1, 1, 0, 32'h0, 16'h0011, 32'hFFFF_FFFF, "R5");
        apply(1, 0, 0, 32'h0, 16'h0010, '0, "R5");
        apply(1, 0, 0, 32'h2, 16'h0010, '0, "R5");
        apply(1, 0, 0, 32'h1, 16'h0002, '0, "R5");
        // R7: req_byte ignored on a store
        apply(1, 1, 1, 32'h0, 16'h0020, 32'h5566_7788, "R7");
        apply(1, 0, 0, 32'h0, 16'h0020, '0, "R7");
        apply(1, 1, 1, 32'h0, 16'h0023, 32'h9999_9999, "R5");
        apply(1, 0, 0, 32'h0, 16'h0020, '0, "R5");
        idle(); idle();
        // R4/R8 and mixed traffic
        for (int n = 0; n < 400; n++) begin
            logic [31:0] b;
            logic [15:0] o;
            lfsr = step_lfsr(lfsr); b = lfsr;
            lfsr = step_lfsr(lfsr); o = lfsr[15:0];
            if (lfsr[20]) o[1:0] = 2'b00;
            if (lfsr[21]) b[1:0] = 2'b00;
            lfsr = step_lfsr(lfsr);
            case (lfsr[2:0])
                3'd0: idle();
                3'd1, 3'd2: begin
                    apply(1, 1, lfsr[5], b, o, lfsr ^ 32'h3C5A_9687, "R2");
                    apply(1, 0, 0, b, o, '0, "R8");
                end
                3'd3: apply(1, 0, 1, b, o, '0, "R6");
                default: apply(1, 0, 0, b, o, '0, "R3");
            endcase
        end
        idle();
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule